// File: doc/BRIEF.md
# JTAG Scan-Chain to Wishbone Bus Bridge

This block lets a debug host reach an on-chip Wishbone bus through the JTAG data path. A TAP controller and instruction decoder, which live outside the block, hand it three decoded select lines: address, read-only data and read-write data. They also hand it the capture, shift and update strobes of the data-register scan. All of these are synchronous to TCK. The bridge keeps a 16-bit bus address and an 8-bit data scan register. It runs the bus accesses as classic single-beat Wishbone cycles on a separate system clock.

An address scan shifts in a new 16-bit address, least significant bit first, and shifts out the one it replaces. In read-only mode, each 8-bit data scan returns the byte at the current address and then moves to the next address. In read-write mode, each 8-bit data scan returns the byte stored at the current address, writes the byte shifted in over it, and then moves on. This makes streaming through memory a matter of repeated data scans.

Requests cross into the system clock domain as a toggle through a two-stage synchronizer. Completions return the same way.

The TCK side has three states:
- IDLE: accepts strobes.
- RD_WAIT: entered from IDLE on capture with either data select.
- WR_WAIT: entered from IDLE on update with the read-write select.

Both wait states return to IDLE when the returned toggle matches the issued one.

The bus side has two states:
- BUS_IDLE: moves to BUS_ACTIVE when a new request toggle arrives.
- BUS_ACTIVE: returns to BUS_IDLE on ack.

The host must leave the TAP idle for a few TCK periods after capture and after update so the access can finish.

Top module: `jtag_wb_bridge`

## Requirements
- R1: After reset, wb_cyc_o and wb_stb_o are low and the current address is 0x0000.
- R2: With sel_addr high, capture loads the current address into a 16-bit scan register. Shift moves it toward tdo, LSB first, with tdi entering at the MSB. Update makes the shifted-in value the current address, so each address scan returns the previous address.
- R3: With sel_rdwr high, capture reads the byte at the current address into the 8-bit scan register, which is shifted out LSB first. Update then writes the shifted-in byte to that same address.
- R4: With sel_read high, capture reads the byte at the current address and shifts it out LSB first. The shifted-in bits are ignored and no write cycle is issued.
- R5: The address increases by one after each data access: after the read in read-only mode, and after the write in read-write mode. It wraps from 0xFFFF to 0x0000.
- R6: A bus cycle raises wb_cyc_o and wb_stb_o together, with wb_we_o high only for writes. It holds address, data and wb_we_o steady until wb_ack_i, and ends in the cycle after ack.
- R7: A read-only access makes exactly one bus cycle. A read-write access makes exactly two: one read and one write.
- R8: sys_rst drops a bus cycle that is in progress, even one stalled without ack. It releases the waiting TCK side, which treats the access as finished and advances the address. Later accesses then work normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, TCK domain |
| sel_addr | input | 1 | Decoded select: address scan register |
| sel_read | input | 1 | Decoded select: read-only data access |
| sel_rdwr | input | 1 | Decoded select: read-write data access |
| capture_dr | input | 1 | Capture strobe from TAP controller |
| shift_dr | input | 1 | Shift strobe from TAP controller |
| update_dr | input | 1 | Update strobe from TAP controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (LSB of selected scan register) |
| sys_clk | input | 1 | System bus clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| wb_adr_o | output | 16 | Bus address |
| wb_dat_o | output | 8 | Bus write data |
| wb_dat_i | input | 8 | Bus read data |
| wb_we_o | output | 1 | Bus write enable |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
The bench streams a run of twelve bytes through read-write mode twice, with two arithmetic value sequences, so each returned byte must match the one written on the earlier pass and not the one being shifted in. A read-only pass over the same range uses a tdi pattern unrelated to memory, which tells a correct read apart from an echo of tdi or an unintended write. Walking-one address scans check every address bit and the previous-value return. A pass across 0xFFFF checks the wrap. Finally, a stalled slave combined with a system reset separates a clean abort from a hung or replayed access.

// File: rtl/jwb_pkg.sv
package jwb_pkg;

    typedef enum logic [1:0] {
        IDLE,
        RD_WAIT,
        WR_WAIT
    } scan_state_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_ACTIVE
    } bus_state_e;

endpackage

// File: rtl/jwb_toggle_sync.sv
module jwb_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= d;
            end else begin : g_next
                always_ff @(posedge clk) chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/jwb_scan_ctrl.sv
module jwb_scan_ctrl
    import jwb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              tck,
    input  logic              tck_rst,
    input  logic              sel_addr,
    input  logic              sel_read,
    input  logic              sel_rdwr,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic              req_tgl,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_adr,
    output logic [DATA_W-1:0] req_dat,
    input  logic              ack_tgl_s,
    input  logic [DATA_W-1:0] rsp_dat
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    scan_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] asr_q;
    logic [DATA_W-1:0] dsr_q;
    logic [DATA_W-1:0] wdat_q;
    logic              tgl_q;
    logic              we_q;
    logic              rd_incr_q;
    logic              data_sel;
    logic              done;

    assign data_sel = sel_read | sel_rdwr;
    assign done     = (tgl_q == ack_tgl_s);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE: begin
                if (capture_dr && data_sel) begin
                    state_d = RD_WAIT;
                end else if (update_dr && sel_rdwr) begin
                    state_d = WR_WAIT;
                end
            end
            RD_WAIT: if (done) state_d = IDLE;
            WR_WAIT: if (done) state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    // state register
    always_ff @(posedge tck) begin
        if (tck_rst) state_q <= IDLE;
        else         state_q <= state_d;
    end

    // datapath and request outputs
    always_ff @(posedge tck) begin
        if (tck_rst) begin
            addr_q    <= '0;
            asr_q     <= '0;
            dsr_q     <= '0;
            wdat_q    <= '0;
            tgl_q     <= 1'b0;
            we_q      <= 1'b0;
            rd_incr_q <= 1'b0;
        end else begin
            unique case (state_q)
                IDLE: begin
                    if (capture_dr) begin
                        if (sel_addr) begin
                            asr_q <= addr_q;
                        end else if (data_sel) begin
                            tgl_q     <= ~tgl_q;
                            we_q      <= 1'b0;
                            rd_incr_q <= sel_read;
                        end
                    end else if (shift_dr) begin
                        if (sel_addr) begin
                            asr_q <= {tdi, asr_q[ADDR_W-1:1]};
                        end else if (data_sel) begin
                            dsr_q <= {tdi, dsr_q[DATA_W-1:1]};
                        end
                    end else if (update_dr) begin
                        if (sel_addr) begin
                            addr_q <= asr_q;
                        end else if (sel_rdwr) begin
                            wdat_q <= dsr_q;
                            we_q   <= 1'b1;
                            tgl_q  <= ~tgl_q;
                        end
                    end
                end
                RD_WAIT: begin
                    if (done) begin
                        dsr_q <= rsp_dat;
                        if (rd_incr_q) addr_q <= addr_q + ADDR_ONE;
                    end
                end
                WR_WAIT: begin
                    if (done) addr_q <= addr_q + ADDR_ONE;
                end
                default: ;
            endcase
        end
    end

    assign tdo     = sel_addr ? asr_q[0] : dsr_q[0];
    assign req_tgl = tgl_q;
    assign req_we  = we_q;
    assign req_adr = addr_q;
    assign req_dat = wdat_q;

endmodule

// File: rtl/jwb_bus_master.sv
module jwb_bus_master
    import jwb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_tgl_s,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_adr,
    input  logic [DATA_W-1:0] req_dat,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] rsp_dat,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic              wb_we_o,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    input  logic              wb_ack_i
);

    bus_state_e state_q, state_d;

    logic              seen_q;
    logic              ack_q;
    logic [ADDR_W-1:0] adr_q;
    logic [DATA_W-1:0] dat_q;
    logic              we_q;
    logic [DATA_W-1:0] rsp_q;
    logic              new_req;

    assign new_req = (seen_q != req_tgl_s);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (new_req)  state_d = BUS_ACTIVE;
            BUS_ACTIVE: if (wb_ack_i) state_d = BUS_IDLE;
            default:                  state_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    // request capture and response; reset swallows any request in flight
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= req_tgl_s;
            ack_q  <= req_tgl_s;
            adr_q  <= '0;
            dat_q  <= '0;
            we_q   <= 1'b0;
            rsp_q  <= '0;
        end else begin
            unique case (state_q)
                BUS_IDLE: begin
                    if (new_req) begin
                        seen_q <= req_tgl_s;
                        adr_q  <= req_adr;
                        dat_q  <= req_dat;
                        we_q   <= req_we;
                    end
                end
                BUS_ACTIVE: begin
                    if (wb_ack_i) begin
                        if (!we_q) rsp_q <= wb_dat_i;
                        ack_q <= ~ack_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // bus outputs
    always_comb begin
        wb_cyc_o = (state_q == BUS_ACTIVE);
        wb_stb_o = (state_q == BUS_ACTIVE);
        wb_we_o  = (state_q == BUS_ACTIVE) && we_q;
        wb_adr_o = adr_q;
        wb_dat_o = dat_q;
    end

    assign ack_tgl = ack_q;
    assign rsp_dat = rsp_q;

endmodule

// File: rtl/jtag_wb_bridge.sv
module jtag_wb_bridge #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              tck,
    input  logic              tck_rst,
    input  logic              sel_addr,
    input  logic              sel_read,
    input  logic              sel_rdwr,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              sys_clk,
    input  logic              sys_rst,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic              wb_we_o,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    input  logic              wb_ack_i
);

    logic              req_tgl;
    logic              req_tgl_s;
    logic              req_we;
    logic [ADDR_W-1:0] req_adr;
    logic [DATA_W-1:0] req_dat;
    logic              ack_tgl;
    logic              ack_tgl_s;
    logic [DATA_W-1:0] rsp_dat;

    jwb_scan_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_scan (
        .tck        (tck),
        .tck_rst    (tck_rst),
        .sel_addr   (sel_addr),
        .sel_read   (sel_read),
        .sel_rdwr   (sel_rdwr),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo),
        .req_tgl    (req_tgl),
        .req_we     (req_we),
        .req_adr    (req_adr),
        .req_dat    (req_dat),
        .ack_tgl_s  (ack_tgl_s),
        .rsp_dat    (rsp_dat)
    );

    jwb_toggle_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk (sys_clk),
        .d   (req_tgl),
        .q   (req_tgl_s)
    );

    jwb_toggle_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk (tck),
        .d   (ack_tgl),
        .q   (ack_tgl_s)
    );

    jwb_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus (
        .clk       (sys_clk),
        .rst       (sys_rst),
        .req_tgl_s (req_tgl_s),
        .req_we    (req_we),
        .req_adr   (req_adr),
        .req_dat   (req_dat),
        .ack_tgl   (ack_tgl),
        .rsp_dat   (rsp_dat),
        .wb_adr_o  (wb_adr_o),
        .wb_dat_o  (wb_dat_o),
        .wb_dat_i  (wb_dat_i),
        .wb_we_o   (wb_we_o),
        .wb_cyc_o  (wb_cyc_o),
        .wb_stb_o  (wb_stb_o),
        .wb_ack_i  (wb_ack_i)
    );

endmodule

// File: rtl/jwb_bridge_checker.sv
module jwb_bridge_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              sys_clk,
    input logic              sys_rst,
    input logic              wb_cyc_o,
    input logic              wb_stb_o,
    input logic              wb_we_o,
    input logic              wb_ack_i,
    input logic [ADDR_W-1:0] wb_adr_o,
    input logic [DATA_W-1:0] wb_dat_o
);

    // R6: strobe is held until the slave acknowledges
    assert_hold_until_ack_R6: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wb_stb_o && !wb_ack_i) |=> wb_stb_o);

    // R6: address, data and direction stay put while waiting
    assert_stable_request_R6: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wb_stb_o && !wb_ack_i) |=> ($stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_we_o)));

    // R6: cycle and strobe travel together, write enable only inside a cycle
    assert_cyc_with_stb_R6: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wb_cyc_o == wb_stb_o) && (!wb_we_o || wb_cyc_o));

    // R7: one beat per request, the cycle ends after ack
    assert_single_beat_R7: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (wb_stb_o && wb_ack_i) |=> !wb_stb_o);

    // R8: reset clears the bus cycle
    assert_reset_idle_R8: assert property (@(posedge sys_clk)
        sys_rst |=> (!wb_cyc_o && !wb_stb_o));

endmodule

bind jtag_wb_bridge jwb_bridge_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_checker (
    .sys_clk  (sys_clk),
    .sys_rst  (sys_rst),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_we_o  (wb_we_o),
    .wb_ack_i (wb_ack_i),
    .wb_adr_o (wb_adr_o),
    .wb_dat_o (wb_dat_o)
);

// File: tb/test_jtag_wb_bridge.sv
module test_jtag_wb_bridge;

    logic        tck = 1'b0;
    logic        sys_clk = 1'b0;
    logic        tck_rst = 1'b1;
    logic        sys_rst = 1'b1;
    logic        sel_addr = 1'b0;
    logic        sel_read = 1'b0;
    logic        sel_rdwr = 1'b0;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [15:0] wb_adr_o;
    logic [7:0]  wb_dat_o;
    logic [7:0]  wb_dat_i;
    logic        wb_we_o;
    logic        wb_cyc_o;
    logic        wb_stb_o;
    logic        wb_ack_i;

    jtag_wb_bridge i_jtag_wb_bridge (
        .tck        (tck),
        .tck_rst    (tck_rst),
        .sel_addr   (sel_addr),
        .sel_read   (sel_read),
        .sel_rdwr   (sel_rdwr),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo),
        .sys_clk    (sys_clk),
        .sys_rst    (sys_rst),
        .wb_adr_o   (wb_adr_o),
        .wb_dat_o   (wb_dat_o),
        .wb_dat_i   (wb_dat_i),
        .wb_we_o    (wb_we_o),
        .wb_cyc_o   (wb_cyc_o),
        .wb_stb_o   (wb_stb_o),
        .wb_ack_i   (wb_ack_i)
    );

    // 50 MHz system clock; slower TCK, phase-shifted off the system edges
    always #10 sys_clk = ~sys_clk;
    initial begin
        #5;
        forever #50 tck = ~tck;
    end

    // slave memory model
    logic [7:0] slave_mem [0:1023];
    logic       mem_clear = 1'b1;
    logic       stall = 1'b0;
    int         n_acks = 0;
    int         n_writes = 0;

    always @(posedge sys_clk) begin
        if (mem_clear) begin
            for (int i = 0; i < 1024; i++) slave_mem[i] <= 8'h00;
            wb_ack_i <= 1'b0;
            wb_dat_i <= 8'h00;
        end else if (sys_rst) begin
            wb_ack_i <= 1'b0;
        end else if (wb_cyc_o && wb_stb_o && !wb_ack_i && !stall) begin
            wb_ack_i <= 1'b1;
            n_acks = n_acks + 1;
            if (wb_we_o) begin
                slave_mem[wb_adr_o[9:0]] <= wb_dat_o;
                n_writes = n_writes + 1;
            end else begin
                wb_dat_i <= slave_mem[wb_adr_o[9:0]];
            end
        end else begin
            wb_ack_i <= 1'b0;
        end
    end

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] exp_addr = 16'h0000;
    logic [7:0]  exp_mem [0:1023];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic set_mode(input int m);
        @(negedge tck);
        sel_addr = (m == 0);
        sel_read = (m == 1);
        sel_rdwr = (m == 2);
    endtask

    task automatic pulse_capture();
        @(negedge tck); capture_dr = 1'b1;
        @(negedge tck); capture_dr = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge tck); update_dr = 1'b1;
        @(negedge tck); update_dr = 1'b0;
    endtask

    task automatic dr_scan(input logic [15:0] din, input int nbits, output logic [15:0] dout);
        pulse_capture();
        repeat (12) @(negedge tck);
        dout = '0;
        for (int i = 0; i < nbits; i++) begin
            shift_dr = 1'b1;
            tdi      = din[i];
            dout[i]  = tdo;
            @(negedge tck);
        end
        shift_dr = 1'b0;
        update_dr = 1'b1;
        @(negedge tck); update_dr = 1'b0;
        repeat (12) @(negedge tck);
    endtask

    task automatic addr_scan(input logic [15:0] newa, input string req);
        logic [15:0] d;
        set_mode(0);
        dr_scan(newa, 16, d);
        check(req, {16'h0, d}, {16'h0, exp_addr});
        exp_addr = newa;
    endtask

    task automatic rdwr_byte(input logic [7:0] v);
        logic [15:0] d;
        set_mode(2);
        dr_scan({8'h00, v}, 8, d);
        check("R3 returned byte", {24'h0, d[7:0]}, {24'h0, exp_mem[exp_addr[9:0]]});
        exp_mem[exp_addr[9:0]] = v;
        exp_addr = exp_addr + 16'h1;
    endtask

    task automatic read_byte(input logic [7:0] junk);
        logic [15:0] d;
        set_mode(1);
        dr_scan({8'h00, junk}, 8, d);
        check("R4 read byte", {24'h0, d[7:0]}, {24'h0, exp_mem[exp_addr[9:0]]});
        exp_addr = exp_addr + 16'h1;
    endtask

    task automatic compare_region(input logic [15:0] base, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [9:0] k;
            k = base[9:0] + 10'(i);
            check(req, {24'h0, slave_mem[k]}, {24'h0, exp_mem[k]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge sys_clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    localparam logic [15:0] BASE = 16'h00F8;
    localparam int          NB   = 12;

    initial begin
        int a0, w0;
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'h00;
        repeat (4) @(negedge tck);
        tck_rst   = 1'b0;
        sys_rst   = 1'b0;
        mem_clear = 1'b0;
        repeat (4) @(negedge tck);

        // R1: bus idle, address zero after reset
        check("R1 cyc", {31'h0, wb_cyc_o}, 32'h0);
        check("R1 stb", {31'h0, wb_stb_o}, 32'h0);
        addr_scan(BASE, "R1 reset address");

        // R3: first read-write pass, memory starts at zero
        a0 = n_acks; w0 = n_writes;
        for (int i = 0; i < NB; i++) rdwr_byte(8'((i * 37 + 11) & 8'hFF));
        compare_region(BASE, NB, "R3 written bytes");
        check("R7 rdwr cycles", n_acks - a0, 2 * NB);
        check("R7 rdwr writes", n_writes - w0, NB);

        // R5: address advanced once per access
        addr_scan(BASE, "R5 after rdwr pass");

        // R3: second pass returns the first pass values
        for (int i = 0; i < NB; i++) rdwr_byte(8'((i * 91 + 200) & 8'hFF));
        compare_region(BASE, NB, "R3 overwritten bytes");
        addr_scan(BASE, "R5 after second pass");

        // R4: read-only pass, tdi pattern must be ignored
        a0 = n_acks; w0 = n_writes;
        for (int i = 0; i < NB; i++) read_byte(8'(8'hA5 ^ (i * 13)));
        check("R4 no writes", n_writes - w0, 0);
        check("R7 read cycles", n_acks - a0, NB);
        compare_region(BASE, NB, "R4 memory unchanged");

        // R5: wrap across the top of the address space
        addr_scan(16'hFFFE, "R5 after read pass");
        for (int i = 0; i < 3; i++) read_byte(8'hFF);
        addr_scan(16'h0000, "R5 wrap");

        // R2: walking-one addresses, each scan returns the previous one
        for (int k = 0; k < 16; k++) addr_scan(16'h1 << k, "R2 walking one");

        // R8: reset while the slave stalls
        addr_scan(16'h0040, "R2 before abort");
        rdwr_byte(8'h3C);
        rdwr_byte(8'hC3);
        addr_scan(16'h0040, "R5 before abort");
        set_mode(1);
        @(negedge tck); stall = 1'b1;
        pulse_capture();
        repeat (6) @(negedge tck);
        check("R6 cycle held while stalled", {31'h0, wb_cyc_o}, 32'h1);
        check("R6 read direction", {31'h0, wb_we_o}, 32'h0);
        sys_rst = 1'b1;
        repeat (3) @(negedge tck);
        check("R8 cyc dropped in reset", {31'h0, wb_cyc_o}, 32'h0);
        sys_rst = 1'b0;
        stall   = 1'b0;
        repeat (12) @(negedge tck);
        check("R8 no replay", {31'h0, wb_cyc_o}, 32'h0);
        pulse_update();
        exp_addr = exp_addr + 16'h1;
        read_byte(8'h00);
        addr_scan(16'h0000, "R8 address after abort");

        finish_run();
    end

endmodule